// File: doc/BRIEF.md
# Fine-Scroll Display Address Generator

This block generates the memory fetch address for each display line of a character-oriented bitmap screen. In this layout every character cell holds eight consecutive bytes, one per pixel line, and each cell of a line is eight bytes beyond the previous one. Software writes a screen start address through two byte-wide registers, and chooses how finely that address may be placed. Coarse placement gives 64 bytes, cell placement gives 8 bytes, and fine placement gives 2 bytes. Fine placement allows scrolling by less than a character height.

When the start address falls inside a character cell, the first character row on screen is cut short. The last row then holds only the remaining lines. The block records both partial line counts for the frame. It can also force a band of lines at the bottom of the active area to blank, so that a split character row does not show content in the wrong place. The fetch address wraps from the top of screen memory back to a configured base.

Register writes, the granularity choice and the band-blank enable are captured only at a frame start pulse. A pixel serialiser drains fetches through a valid/ready pair. `fetch_valid` rises after a line strobe and stays high with `fetch_addr` held steady until `fetch_ready` accepts the byte. The consumer may hold `fetch_ready` low for as long as it likes, and the block waits. Sync generation and pixel output are handled elsewhere.

Top module: `fine_scroll_addr_gen`

## Requirements
- R1: With `reg_sel`=0 a write loads start address bits 7:0 from `reg_wdata`. With `reg_sel`=1 it loads bits 14:8 from `reg_wdata[6:0]`, and `reg_wdata[7]` is ignored. A written value, `gran_sel` and `band_blank_en` affect fetches only from the next `frame_start` on, not in the frame already running.
- R2: At `frame_start` the start address is masked by `gran_sel`. 2'b00 clears bits 5:0 (64-byte steps), 2'b01 clears bits 2:0 (8-byte steps), and 2'b10 or 2'b11 clears bit 0 (2-byte steps).
- R3: Let S be the masked start, o = S mod 8 and n = o + L. For active line L, byte k is fetched from address (S - o) + (n div 8)·STRIDE + 8k + (n mod 8). STRIDE = 8·BYTES_PER_LINE.
- R4: Address arithmetic wraps inside screen memory. Any sum at or above 2^ADDR_W is brought back by subtracting 2^ADDR_W − WRAP_BASE, so every fetch address lies in [WRAP_BASE, 2^ADDR_W).
- R5: After `frame_start`, `head_lines` gives the line count of the first partial character row, which is 8 − o, or 0 when o = 0. `tail_lines` gives the final partial row count o. For o = 2 these are 6 and 2, with 31 full rows between them over 256 lines.
- R6: Line strobes are numbered from 0 after each `frame_start`. Lines numbered ACTIVE_LINES (default 256) or more, up to FRAME_LINES (default 312), have `line_blank` high and make no fetch.
- R7: When `band_blank_en` was high at `frame_start`, the last BLANK_LINES (default 6) active lines have `line_blank` high and make no fetch. With the defaults that leaves 250 lines showing. Otherwise those lines fetch normally.
- R8: An unblanked active line makes exactly BYTES_PER_LINE handshakes and then drops `fetch_valid`. While `fetch_valid` is high and `fetch_ready` is low, `fetch_valid` and `fetch_addr` hold.
- R9: After reset, `fetch_valid` is 0, `line_blank` is 1, and `head_lines` and `tail_lines` are 0.
- R10: A `frame_start` pulse ends any line in progress. From the next cycle `fetch_valid` is 0 and `line_blank` is 1 until the next line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the low address byte, 1 the high byte |
| reg_wdata | input | 8 | Register write data |
| gran_sel | input | 2 | Scroll granularity, sampled at frame start |
| band_blank_en | input | 1 | Bottom band blank enable, sampled at frame start |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| fetch_ready | input | 1 | Consumer accepts the current fetch |
| fetch_valid | output | 1 | A fetch address is offered |
| fetch_addr | output | ADDR_W (15) | Byte address to fetch |
| line_blank | output | 1 | Current line is blank |
| head_lines | output | 4 | Lines in the first partial character row |
| tail_lines | output | 4 | Lines in the final partial character row |

## Verification
The assertions assume that the masked start address lies inside screen memory, at or above WRAP_BASE. They also assume that `frame_start` and `line_strobe` are single-cycle pulses that never coincide. The bench draws start addresses only from the screen window and pulses each strobe for exactly one cycle. It issues a line strobe only after the previous line's fetches have drained. It holds `fetch_ready` low for random stretches to exercise back-pressure, while register writes and granularity changes in the middle of a frame stay between lines.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  localparam int CELL_W = 3;            // eight lines per character cell
  localparam int CELL_LINES = 1 << CELL_W;

  typedef enum logic [1:0] {
    GRAN_COARSE = 2'b00,
    GRAN_CELL   = 2'b01,
    GRAN_FINE   = 2'b10,
    GRAN_FINE_A = 2'b11
  } gran_e;

  // add with wrap into [base, top)
  function automatic logic [31:0] wrap_add(input logic [31:0] a, input logic [31:0] inc,
                                           input logic [31:0] base, input logic [31:0] top);
    logic [31:0] s;
    s = a + inc;
    if (s >= top) s = s - top + base;
    return s;
  endfunction

endpackage

// File: rtl/fsa_start_regs.sv
module fsa_start_regs #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic [1:0]        gran_sel,
  output logic [ADDR_W-1:0] start_masked
);
  import fsa_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic [ADDR_W-1:0] keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel) hi_q <= reg_wdata[HI_W-1:0];
      else         lo_q <= reg_wdata;
    end
  end

  always_comb begin
    keep = '1;
    case (gran_e'(gran_sel))
      GRAN_COARSE: keep[5:0] = '0;
      GRAN_CELL:   keep[CELL_W-1:0] = '0;
      default:     keep[0] = 1'b0;
    endcase
    start_masked = {hi_q, lo_q} & keep;
  end

endmodule

// File: rtl/fsa_line_ptr.sv
module fsa_line_ptr #(
  parameter int ADDR_W         = 15,
  parameter int STRIDE         = 640,
  parameter int ACTIVE_LINES   = 256,
  parameter int FRAME_LINES    = 312,
  parameter int BLANK_LINES    = 6,
  parameter logic [ADDR_W-1:0] WRAP_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_strobe,
  input  logic              band_blank_en,
  input  logic [ADDR_W-1:0] start_masked,
  output logic              line_load,
  output logic              line_go,
  output logic [ADDR_W-1:0] line_addr,
  output logic              line_blank,
  output logic [fsa_pkg::CELL_W:0] head_lines,
  output logic [fsa_pkg::CELL_W:0] tail_lines
);
  import fsa_pkg::*;

  localparam int LW  = $clog2(FRAME_LINES + 1);
  localparam int TOP = 1 << ADDR_W;
  localparam logic [LW-1:0] ACT_END  = LW'(ACTIVE_LINES);
  localparam logic [LW-1:0] BAND_BEG = LW'(ACTIVE_LINES - BLANK_LINES);
  localparam logic [LW-1:0] LINE_MAX = LW'(FRAME_LINES);

  logic [ADDR_W-1:CELL_W] row_base;
  logic [CELL_W-1:0]      cell_line;
  logic [LW-1:0]          nxt_line;
  logic                   band_q;
  logic [31:0]            row_next;
  logic [CELL_W-1:0]      off;

  assign off       = start_masked[CELL_W-1:0];
  assign line_load = line_strobe && !frame_start;
  assign line_addr = {row_base, cell_line};
  assign line_go   = (nxt_line < ACT_END) && !(band_q && nxt_line >= BAND_BEG);
  assign row_next  = wrap_add(32'({row_base, {CELL_W{1'b0}}}), 32'(STRIDE),
                              32'(WRAP_BASE), 32'(TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_base   <= WRAP_BASE[ADDR_W-1:CELL_W];
      cell_line  <= '0;
      nxt_line   <= '0;
      band_q     <= 1'b0;
      line_blank <= 1'b1;
      head_lines <= '0;
      tail_lines <= '0;
    end else if (frame_start) begin
      row_base   <= start_masked[ADDR_W-1:CELL_W];
      cell_line  <= off;
      nxt_line   <= '0;
      band_q     <= band_blank_en;
      line_blank <= 1'b1;
      head_lines <= (off == '0) ? '0 : (CELL_W+1)'(CELL_LINES) - {1'b0, off};
      tail_lines <= {1'b0, off};
    end else if (line_load) begin
      line_blank <= !line_go;
      if (nxt_line != LINE_MAX) nxt_line <= nxt_line + 1'b1;
      cell_line <= cell_line + 1'b1;
      if (cell_line == CELL_W'(CELL_LINES - 1)) row_base <= row_next[ADDR_W-1:CELL_W];
    end
  end

endmodule

// File: rtl/fsa_fetch.sv
module fsa_fetch #(
  parameter int ADDR_W         = 15,
  parameter int BYTES_PER_LINE = 80,
  parameter logic [ADDR_W-1:0] WRAP_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_load,
  input  logic              line_go,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr
);
  import fsa_pkg::*;

  localparam int CW  = $clog2(BYTES_PER_LINE + 1);
  localparam int TOP = 1 << ADDR_W;

  logic [CW-1:0] left;
  logic [31:0]   addr_next;

  assign fetch_valid = (left != '0);
  assign addr_next   = wrap_add(32'(fetch_addr), 32'(CELL_LINES), 32'(WRAP_BASE), 32'(TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left       <= '0;
      fetch_addr <= '0;
    end else if (frame_start) begin
      left <= '0;
    end else if (line_load) begin
      fetch_addr <= line_addr;
      left       <= line_go ? CW'(BYTES_PER_LINE) : '0;
    end else if (fetch_valid && fetch_ready) begin
      fetch_addr <= addr_next[ADDR_W-1:0];
      left       <= left - 1'b1;
    end
  end

endmodule

// File: rtl/fine_scroll_addr_gen.sv
module fine_scroll_addr_gen #(
  parameter int ADDR_W         = 15,
  parameter int BYTES_PER_LINE = 80,
  parameter int ACTIVE_LINES   = 256,
  parameter int FRAME_LINES    = 312,
  parameter int BLANK_LINES    = 6,
  parameter logic [ADDR_W-1:0] WRAP_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic [1:0]        gran_sel,
  input  logic              band_blank_en,
  input  logic              frame_start,
  input  logic              line_strobe,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              line_blank,
  output logic [3:0]        head_lines,
  output logic [3:0]        tail_lines
);

  localparam int STRIDE = BYTES_PER_LINE * fsa_pkg::CELL_LINES;

  logic [ADDR_W-1:0] start_masked;
  logic [ADDR_W-1:0] line_addr;
  logic              line_load;
  logic              line_go;

  fsa_start_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .gran_sel     (gran_sel),
    .start_masked (start_masked)
  );

  fsa_line_ptr #(
    .ADDR_W       (ADDR_W),
    .STRIDE       (STRIDE),
    .ACTIVE_LINES (ACTIVE_LINES),
    .FRAME_LINES  (FRAME_LINES),
    .BLANK_LINES  (BLANK_LINES),
    .WRAP_BASE    (WRAP_BASE)
  ) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .line_strobe   (line_strobe),
    .band_blank_en (band_blank_en),
    .start_masked  (start_masked),
    .line_load     (line_load),
    .line_go       (line_go),
    .line_addr     (line_addr),
    .line_blank    (line_blank),
    .head_lines    (head_lines),
    .tail_lines    (tail_lines)
  );

  fsa_fetch #(
    .ADDR_W         (ADDR_W),
    .BYTES_PER_LINE (BYTES_PER_LINE),
    .WRAP_BASE      (WRAP_BASE)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_load   (line_load),
    .line_go     (line_go),
    .line_addr   (line_addr),
    .fetch_ready (fetch_ready),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr)
  );

endmodule

// File: rtl/fine_scroll_addr_gen_chk.sv
module fine_scroll_addr_gen_chk #(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] WRAP_BASE = 15'h3000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_strobe,
  input logic              fetch_ready,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              line_blank,
  input logic [3:0]        head_lines,
  input logic [3:0]        tail_lines
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !frame_start && !line_strobe)
      |=> (fetch_valid && $stable(fetch_addr)));

  // R6
  blank_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_blank |-> !fetch_valid);

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_addr >= WRAP_BASE));

  // R5
  partial_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, head_lines} + {1'b0, tail_lines}) == 5'd0) ||
    (({1'b0, head_lines} + {1'b0, tail_lines}) == 5'd8));

  // R10
  frame_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!fetch_valid && line_blank));

  // R3
  cell_line_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !frame_start && !line_strobe)
      |=> (fetch_addr[2:0] == $past(fetch_addr[2:0])));

endmodule

bind fine_scroll_addr_gen fine_scroll_addr_gen_chk #(
  .ADDR_W    (ADDR_W),
  .WRAP_BASE (WRAP_BASE)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_strobe (line_strobe),
  .fetch_ready (fetch_ready),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .line_blank  (line_blank),
  .head_lines  (head_lines),
  .tail_lines  (tail_lines)
);

// File: tb/test_fine_scroll_addr_gen.sv
`timescale 1ns/1ps
module test_fine_scroll_addr_gen;

  localparam int AW    = 15;
  localparam int BPL   = 10;
  localparam int ACT   = 32;
  localparam int FRM   = 40;
  localparam int BLK   = 6;
  localparam int BASE  = 'h7C00;
  localparam int TOP   = 1 << AW;
  localparam int WIN   = TOP - BASE;
  localparam int STR   = BPL * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] gran_sel = '0;
  logic band_blank_en = 1'b0;
  logic frame_start = 1'b0;
  logic line_strobe = 1'b0;
  logic fetch_ready = 1'b0;
  logic fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic line_blank;
  logic [3:0] head_lines;
  logic [3:0] tail_lines;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fine_scroll_addr_gen #(
    .ADDR_W(AW), .BYTES_PER_LINE(BPL), .ACTIVE_LINES(ACT),
    .FRAME_LINES(FRM), .BLANK_LINES(BLK), .WRAP_BASE(AW'(BASE))
  ) i_fine_scroll_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .gran_sel(gran_sel), .band_blank_en(band_blank_en),
    .frame_start(frame_start), .line_strobe(line_strobe), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .line_blank(line_blank),
    .head_lines(head_lines), .tail_lines(tail_lines)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mask_start(input int s, input int g);
    if (g == 0) return s & ~63;
    if (g == 1) return s & ~7;
    return s & ~1;
  endfunction

  function automatic int exp_addr(input int s, input int l, input int k);
    int off = s % 8;
    int n = off + l;
    int rel = ((s - off) - BASE + (n / 8) * STR + k * 8) % WIN;
    return BASE + rel + (n % 8);
  endfunction

  function automatic bit exp_blank(input int l, input bit bl);
    return (l >= ACT) || (bl && l >= ACT - BLK);
  endfunction

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // one line: strobe, then drain fetches with random back-pressure
  task automatic do_line(input int s, input int l, input bit bl);
    int n = 0;
    int guard = 0;
    bit eb;
    @(negedge clk);
    line_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0;
    eb = exp_blank(l, bl);
    // R6 R7 blank flag per line
    chk(line_blank == eb, (l >= ACT) ? "R6 blank outside active" : "R7 band blank", int'(line_blank), int'(eb));
    while (fetch_valid && guard < 1000) begin
      fetch_ready = ($urandom % 4) != 0;
      if (fetch_ready) begin
        // R3 R4 address per line/byte
        chk(int'(fetch_addr) == exp_addr(s, l, n), "R3 R4 fetch address", int'(fetch_addr), exp_addr(s, l, n));
        n++;
      end
      guard++;
      @(negedge clk);
    end
    fetch_ready = 1'b0;
    // R8 byte count per line
    chk(n == (eb ? 0 : BPL), "R8 bytes per line", n, eb ? 0 : BPL);
  endtask

  task automatic run_frame(input int s, input int g, input bit bl, input bit mid);
    int sm = mask_start(s, g);
    int hd = ((sm % 8) == 0) ? 0 : 8 - (sm % 8);
    wr(1'b0, 8'(s));
    wr(1'b1, {1'($urandom), 7'(s >> 8)});   // R1 bit 7 ignored
    gran_sel = 2'(g);
    band_blank_en = bl;
    pulse_frame();
    // R5 partial row counts
    chk(int'(head_lines) == hd, "R5 head lines", int'(head_lines), hd);
    chk(int'(tail_lines) == sm % 8, "R5 tail lines", int'(tail_lines), sm % 8);
    for (int l = 0; l < FRM; l++) begin
      if (mid && l == 3) begin
        // R1 writes mid-frame must not disturb the running frame
        wr(1'b0, 8'(s + 8'h55));
        wr(1'b1, 8'((s >> 8) ^ 8'h03));
        gran_sel = 2'(g + 1);
        band_blank_en = !bl;
      end
      do_line(sm, l, bl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(fetch_valid == 1'b0, "R9 valid after reset", int'(fetch_valid), 0);
    chk(line_blank == 1'b1, "R9 blank after reset", int'(line_blank), 1);
    chk(head_lines == 4'd0 && tail_lines == 4'd0, "R9 partial counts after reset",
        int'({head_lines, tail_lines}), 0);
    rst_n = 1'b1;

    // R2 granularity on one start value, with top-of-memory wrap (R4)
    run_frame('h7F4B, 2, 1'b1, 1'b1);
    run_frame('h7F4B, 1, 1'b0, 1'b0);
    run_frame('h7F4B, 0, 1'b1, 1'b0);
    run_frame('h7F4B, 3, 1'b0, 1'b0);
    run_frame(BASE, 2, 1'b1, 1'b0);
    run_frame(TOP - 2, 2, 1'b0, 1'b0);

    // R10 frame start aborts a line mid-fetch
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h7D);
    gran_sel = 2'd2;
    band_blank_en = 1'b0;
    pulse_frame();
    @(negedge clk);
    line_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0;
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    chk(fetch_valid == 1'b1, "R10 line running before abort", int'(fetch_valid), 1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(fetch_valid == 1'b0, "R10 valid dropped by frame start", int'(fetch_valid), 0);
    chk(line_blank == 1'b1, "R10 blank after frame start", int'(line_blank), 1);

    for (int f = 0; f < 30; f++) begin
      run_frame(BASE + int'($urandom % WIN), int'($urandom % 4), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule